// File: doc/BRIEF.md
# Shadowed Byte SRAM with Store and Recall

This block models a byte-wide static RAM that has a second array of the same size behind it, standing in for a nonvolatile copy. Host access uses three active-low strobes: chip enable, output enable and write enable. It also has an address bus. The bidirectional data bus is split into a data input, a data output and a drive-enable, so a pad ring or a bench can merge them.

A pulse on the store input copies the whole working array into the backing copy. The copy is made in two passes: the first pass clears every backing byte to 0xFF, and the second pass programs the working contents into it. A pulse on the recall input copies the backing array into the working array. Each pass moves one address per clock. While a transfer runs, the block raises busy. During that time it ignores host reads, writes and new requests. Busy is also held for a parameterised minimum number of cycles. A parameter can start a recall straight out of reset.

Top module: `shadow_sram`

## Requirements
- R1: While idle, with chip enable low, output enable low and write enable high, `dq_oe` is 1 and `dout` shows the working byte at `addr` in the same cycle. It follows every address change with no strobe transition.
- R2: A write happens at the rising clock edge whenever chip enable and write enable are both low and the block is idle. The state of output enable does not matter.
- R3: `dq_oe` is 0 whenever write enable is low, chip enable is high, output enable is high, or busy is 1.
- R4: After reset, busy is 0 and every backing byte holds 0xFF.
- R5: A store clears the backing array and then loads it with the working array as it stood when the store began. A later recall returns that data, even if the working array was rewritten in between.
- R6: A recall replaces every working byte with the matching backing byte.
- R7: Busy rises in the cycle after the clock edge that samples a request. A store keeps busy high for max(2·2^AW, MIN_BUSY) cycles. A recall keeps it high for max(2^AW, MIN_BUSY) cycles.
- R8: While busy, host writes do not change the working array, `dq_oe` stays 0, and store or recall requests are dropped.
- R9: If store and recall are requested in the same cycle, the store is performed.
- R10: With RECALL_ON_RESET set to 1, busy is high straight out of reset while a recall runs. After the recall, every working byte reads 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | AW | Byte address |
| din | input | DW | Write data |
| dout | output | DW | Read data |
| dq_oe | output | 1 | Drive enable for the data bus |
| store_req | input | 1 | Start a store (working to backing) |
| recall_req | input | 1 | Start a recall (backing to working) |
| busy | output | 1 | Transfer in progress |

## Verification
The main instance uses AW=6 (64 bytes) and MIN_BUSY=100. With these values a recall is padded out to the minimum time, while a store, at 128 cycles, runs longer than the minimum. Both branches of the busy length are therefore measured, and the store-over-recall choice shows up in the busy length. Every address can be filled, stored, overwritten and recalled within a short run. A second instance with AW=4, MIN_BUSY=0 and RECALL_ON_RESET=1 covers the recall that starts out of reset.

// File: rtl/shadow_sram.sv
module shadow_sram #(
  parameter int AW = 11,
  parameter int DW = 8,
  parameter int MIN_BUSY = 100,
  parameter bit RECALL_ON_RESET = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic          dq_oe,
  input  logic          store_req,
  input  logic          recall_req,
  output logic          busy
);
  localparam int DEPTH = 1 << AW;
  localparam int CW = $clog2(MIN_BUSY + 2);
  localparam logic [CW:0] MINV = (CW+1)'(MIN_BUSY);

  typedef enum logic [2:0] {S_IDLE, S_ERASE, S_PROG, S_RECALL, S_HOLD} st_t;

  st_t st;
  logic [AW-1:0] ptr;
  logic [CW-1:0] tcnt;
  logic [DW-1:0] work [DEPTH];
  logic [DW-1:0] shadow [DEPTH];

  wire [CW:0] tnext = {1'b0, tcnt} + 1'b1;
  wire min_met = tnext >= MINV;
  wire last = &ptr;
  wire host_wr = !busy && !ce_n && !we_n;

  assign busy = (st != S_IDLE);
  assign dq_oe = !busy && !ce_n && !oe_n && we_n;
  assign dout = work[addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= RECALL_ON_RESET ? S_RECALL : S_IDLE;
      ptr <= '0;
      tcnt <= '0;
    end else if (st == S_IDLE) begin
      ptr <= '0;
      tcnt <= '0;
      if (store_req) st <= S_ERASE;
      else if (recall_req) st <= S_RECALL;
    end else begin
      if (tnext <= MINV) tcnt <= tnext[CW-1:0];
      ptr <= ptr + 1'b1;
      case (st)
        S_ERASE: if (last) st <= S_PROG;
        S_PROG, S_RECALL: if (last) st <= min_met ? S_IDLE : S_HOLD;
        S_HOLD: if (min_met) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (st == S_RECALL) work[ptr] <= shadow[ptr];
    else if (host_wr) work[addr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) shadow[i] <= '1;
    end else if (st == S_ERASE) begin
      shadow[ptr] <= '1;
    end else if (st == S_PROG) begin
      shadow[ptr] <= work[ptr];
    end
  end
endmodule

module shadow_sram_chk #(
  parameter int MIN_BUSY = 100
) (
  input logic clk,
  input logic rst_n,
  input logic ce_n,
  input logic oe_n,
  input logic we_n,
  input logic store_req,
  input logic recall_req,
  input logic busy,
  input logic dq_oe
);
  int bcnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bcnt <= 0;
    else if (!busy) bcnt <= 0;
    else if (bcnt < MIN_BUSY) bcnt <= bcnt + 1;
  end

  // R3
  drive_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> (!ce_n && !oe_n && we_n));

  // R8
  busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !dq_oe);

  // R7
  req_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && (store_req || recall_req)) |=> busy);

  // R7
  rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(store_req || recall_req));

  // R7
  min_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (bcnt >= MIN_BUSY));
endmodule

bind shadow_sram shadow_sram_chk #(.MIN_BUSY(MIN_BUSY)) u_chk (.*);

// File: tb/shadow_sram_bench.sv
module shadow_sram_bench;
  localparam int AW = 6;
  localparam int DEPTH = 1 << AW;
  localparam int MINB = 100;

  logic clk = 0, rst_n = 0;
  logic ce_n = 1, oe_n = 1, we_n = 1, store_req = 0, recall_req = 0;
  logic [AW-1:0] addr = '0;
  logic [7:0] din = '0, dout;
  logic dq_oe, busy;

  logic r_ce_n = 1, r_oe_n = 1;
  logic [3:0] r_addr = '0;
  logic [7:0] r_dout;
  logic r_dq_oe, r_busy;

  int checks = 0, fails = 0, cyc = 0;
  logic [7:0] wm [DEPTH];
  logic [7:0] sm [DEPTH];

  always #5 clk = ~clk;

  shadow_sram #(.AW(AW), .DW(8), .MIN_BUSY(MINB), .RECALL_ON_RESET(1'b0)) u_shadow_sram (
    .clk, .rst_n, .ce_n, .oe_n, .we_n, .addr, .din, .dout, .dq_oe,
    .store_req, .recall_req, .busy);

  shadow_sram #(.AW(4), .DW(8), .MIN_BUSY(0), .RECALL_ON_RESET(1'b1)) u_shadow_sram_ror (
    .clk, .rst_n, .ce_n(r_ce_n), .oe_n(r_oe_n), .we_n(1'b1), .addr(r_addr), .din(8'h00),
    .dout(r_dout), .dq_oe(r_dq_oe), .store_req(1'b0), .recall_req(1'b0), .busy(r_busy));

  function automatic int maxi(int a, int b);
    return a > b ? a : b;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      finish_run();
    end
  end

  task automatic wr(int a, logic [7:0] d);
    @(negedge clk);
    ce_n = 0; we_n = 0; oe_n = 1'($urandom_range(0, 1)); addr = AW'(a); din = d;
    #1 chk("R3 write drive", int'(dq_oe), 0);
    @(negedge clk);
    ce_n = 1; we_n = 1; oe_n = 1;
    wm[a] = d;
  endtask

  task automatic read_all(string req);
    @(negedge clk);
    ce_n = 0; oe_n = 0; we_n = 1;
    for (int a = 0; a < DEPTH; a++) begin
      addr = AW'(a);
      #1;
      checks++;
      if (dq_oe !== 1'b1 || dout !== wm[a]) begin
        fails++;
        $display("FAIL %s addr=%0d actual=%0b/%0h expected=1/%0h", req, a, dq_oe, dout, wm[a]);
      end
    end
    @(negedge clk);
    ce_n = 1; oe_n = 1;
  endtask

  task automatic xfer(bit st, bit rc, int exp_len, string req);
    int n = 0;
    @(negedge clk);
    store_req = st; recall_req = rc;
    @(negedge clk);
    store_req = 0; recall_req = 0;
    while (busy && n < 1000) begin
      n++;
      if (n == 10) begin
        ce_n = 0; we_n = 0; oe_n = 0; addr = 5; din = ~wm[5]; recall_req = 1;
        #1 chk("R8 no drive while busy", int'(dq_oe), 0);
      end else begin
        ce_n = 1; we_n = 1; oe_n = 1; recall_req = 0;
      end
      @(negedge clk);
    end
    ce_n = 1; we_n = 1; oe_n = 1; recall_req = 0;
    chk(req, n, exp_len);
    repeat (3) @(negedge clk);
    chk("R8 dropped request", int'(busy), 0);
  endtask

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk("R4 busy after reset", int'(busy), 0);
    chk("R3 idle drive", int'(dq_oe), 0);
    chk("R10 busy out of reset", int'(r_busy), 1);

    for (int a = 0; a < DEPTH; a++) wm[a] = 8'hFF;
    xfer(0, 1, maxi(DEPTH, MINB), "R7 recall length");
    read_all("R4 R6 recall of reset shadow");

    for (int a = 0; a < DEPTH; a++) wr(a, 8'($urandom));
    wr(0, 8'h00);
    wr(DEPTH-1, 8'hFF);
    wr(7, 8'hA5);
    read_all("R1 R2 readback");

    @(negedge clk);
    ce_n = 0; oe_n = 0; we_n = 1;
    for (int k = 0; k < 20; k++) begin
      automatic int a = $urandom_range(0, DEPTH-1);
      addr = AW'(a);
      #1 chk("R1 address follow", int'(dout), int'(wm[a]));
      #2;
    end
    oe_n = 1;
    #1 chk("R3 oe high", int'(dq_oe), 0);
    ce_n = 1;

    for (int a = 0; a < DEPTH; a++) sm[a] = wm[a];
    xfer(1, 1, maxi(2*DEPTH, MINB), "R9 R7 store wins and length");
    read_all("R8 write ignored while busy");

    for (int a = 0; a < DEPTH; a++) wr(a, 8'($urandom));
    read_all("R2 overwrite");

    for (int a = 0; a < DEPTH; a++) wm[a] = sm[a];
    xfer(0, 1, maxi(DEPTH, MINB), "R7 recall length");
    read_all("R5 R6 recall of stored data");

    chk("R10 busy ended", int'(r_busy), 0);
    @(negedge clk);
    r_ce_n = 0; r_oe_n = 0;
    for (int a = 0; a < 16; a++) begin
      r_addr = 4'(a);
      #1 chk("R10 recall on reset data", int'(r_dout), 8'hFF);
    end
    r_ce_n = 1; r_oe_n = 1;

    finish_run();
  end
endmodule